// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block is a single register stage for the command and address lines of a memory module. On every rising clock edge it captures a wide input word and drives it out through registered outputs. Two static configuration inputs decide how the captured bits reach the output pins. The block can act as a straight 25-bit register. It can also act as a 14-bit register whose bits each drive two output pins, laid out in one of two arrangements.

A pair of select inputs can hold every output at its current value. The outputs freeze only when both selects are high at a clock edge. The first select is also registered and driven out as an ordinary data bit. Tying the second select low turns the freeze off for good. An active-low asynchronous reset clears every register and pulls all outputs low at once, and it overrides the freeze.

Top module: `csab_reg_buffer`

## Requirements
- R1: While rst_ni is low, q_o and qcs_o are all zero. Asserting rst_ni clears them at once, without waiting for a clock edge.
- R2: With cfg_split_i low, a loading clock edge sets q_o[24:0] to d_i[24:0] and q_o[27:25] to zero.
- R3: With cfg_split_i high and cfg_alt_i low (bank arrangement), a loading edge sets q_o[k] and q_o[k+14] to d_i[k] for every k in 0..13.
- R4: With cfg_split_i high and cfg_alt_i high (pair arrangement), a loading edge sets q_o[2k] and q_o[2k+1] to d_i[k] for every k in 0..13.
- R5: With cfg_split_i high, d_i[24:14] have no effect on q_o.
- R6: If dcs_i and csr_i are both high at a rising edge, q_o and qcs_o keep their values across that edge.
- R7: If dcs_i or csr_i is low at a rising edge, that edge is a loading edge, and qcs_o takes the value of dcs_i.
- R8: Reset overrides the freeze. With both selects high, a low rst_ni still forces every output to zero.
- R9: A change on cfg_split_i or cfg_alt_i between clock edges leaves the outputs alone. The new arrangement appears from the next loading edge.
- R10: After rst_ni rises, the outputs stay zero for as long as d_i and dcs_i stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_split_i | input | 1 | 0: 25-bit 1:1 register; 1: 14-bit 1:2 register |
| cfg_alt_i | input | 1 | 1:2 arrangement: 0 bank, 1 pair |
| dcs_i | input | 1 | First select; also a registered data bit |
| csr_i | input | 1 | Second select; low disables the freeze |
| d_i | input | 25 | Input word |
| q_o | output | 28 | Registered, fanned-out output word |
| qcs_o | output | 1 | Registered copy of dcs_i |

## Verification
The mapping is tested in all three fanout modes with walking-one and walking-zero words across all 25 inputs. A walking one shows up any output bit that is wired to the wrong input or that is stuck. A walking zero shows up a bit that is ORed with another bit or held high. Pseudo-random words, and 1:2 words that differ only in the upper input bits, show that the duplicate pins track each other and that the unused inputs are ignored. All four select combinations are tried with each mode. Further sequences assert reset in the middle of a cycle while the freeze is active, release it with low data, and change the configuration between edges, which separates asynchronous clearing, reset priority and edge-timed mode switching.

// File: rtl/csab_pkg.sv
`timescale 1ns/1ps
package csab_pkg;
  localparam int unsigned DEF_DATA_W = 25;
  localparam int unsigned DEF_HALF_W = 14;

  typedef enum logic [1:0] {
    FAN_ONE      = 2'b00,
    FAN_DUP_BANK = 2'b10,
    FAN_DUP_PAIR = 2'b11
  } fan_mode_e;
endpackage

// File: rtl/csab_mode_dec.sv
`timescale 1ns/1ps
module csab_mode_dec
  import csab_pkg::*;
(
  input  logic      split_i,
  input  logic      alt_i,
  output fan_mode_e mode_o
);
  always_comb begin
    if (!split_i)   mode_o = FAN_ONE;
    else if (alt_i) mode_o = FAN_DUP_PAIR;
    else            mode_o = FAN_DUP_BANK;
  end
endmodule

// File: rtl/csab_fanout_map.sv
`timescale 1ns/1ps
module csab_fanout_map
  import csab_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned OUT_W = 2 * HALF_W
) (
  input  logic [DATA_W-1:0] d_i,
  input  fan_mode_e         mode_i,
  output logic [OUT_W-1:0]  q_o
);
  logic [OUT_W-1:0] one_w, bank_w, pair_w;

  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    if (j < DATA_W) begin : g_one
      assign one_w[j] = d_i[j];
    end else begin : g_pad
      assign one_w[j] = 1'b0;
    end
    assign bank_w[j] = d_i[j % HALF_W];
    assign pair_w[j] = d_i[j / 2];
  end

  always_comb begin
    unique case (mode_i)
      FAN_DUP_BANK: q_o = bank_w;
      FAN_DUP_PAIR: q_o = pair_w;
      default:      q_o = one_w;
    endcase
  end
endmodule

// File: rtl/csab_hold_gate.sv
`timescale 1ns/1ps
module csab_hold_gate (
  input  logic dcs_i,
  input  logic csr_i,
  output logic load_o
);
  // freeze only when both selects are high
  assign load_o = ~(dcs_i & csr_i);
endmodule

// File: rtl/csab_out_reg.sv
`timescale 1ns/1ps
module csab_out_reg #(
  parameter int unsigned W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/csab_reg_buffer.sv
`timescale 1ns/1ps
module csab_reg_buffer
  import csab_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned OUT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_split_i,
  input  logic              cfg_alt_i,
  input  logic              dcs_i,
  input  logic              csr_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [OUT_W-1:0]  q_o,
  output logic              qcs_o
);
  fan_mode_e        mode_w;
  logic [OUT_W-1:0] mapped_w;
  logic             load_w;
  logic [OUT_W:0]   reg_q;

  csab_mode_dec i_mode_dec (
    .split_i (cfg_split_i),
    .alt_i   (cfg_alt_i),
    .mode_o  (mode_w)
  );

  csab_fanout_map #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_map (
    .d_i    (d_i),
    .mode_i (mode_w),
    .q_o    (mapped_w)
  );

  csab_hold_gate i_gate (
    .dcs_i  (dcs_i),
    .csr_i  (csr_i),
    .load_o (load_w)
  );

  csab_out_reg #(.W(OUT_W + 1)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .d_i    ({dcs_i, mapped_w}),
    .q_o    (reg_q)
  );

  assign q_o   = reg_q[OUT_W-1:0];
  assign qcs_o = reg_q[OUT_W];
endmodule

// File: rtl/csab_reg_buffer_chk.sv
`timescale 1ns/1ps
module csab_reg_buffer_chk #(
  parameter int unsigned DATA_W = 25,
  parameter int unsigned HALF_W = 14,
  localparam int unsigned OUT_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_split_i,
  input logic              cfg_alt_i,
  input logic              dcs_i,
  input logic              csr_i,
  input logic [DATA_W-1:0] d_i,
  input logic [OUT_W-1:0]  q_o,
  input logic              qcs_o
);
  function automatic logic [OUT_W-1:0] spread_pair(input logic [HALF_W-1:0] h);
    logic [OUT_W-1:0] r;
    for (int k = 0; k < HALF_W; k++) begin
      r[2*k]   = h[k];
      r[2*k+1] = h[k];
    end
    return r;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !qcs_o)); // R1

  AST_RESET_OVER_HOLD: assert property (@(posedge clk_i)
    (!rst_ni && dcs_i && csr_i) |-> (q_o == '0)); // R8

  AST_ONE_TO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(dcs_i && csr_i) && !cfg_split_i) |=>
      (q_o[DATA_W-1:0] == $past(d_i) && q_o[OUT_W-1:DATA_W] == '0)); // R2

  AST_DUP_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(dcs_i && csr_i) && cfg_split_i && !cfg_alt_i) |=>
      (q_o[HALF_W-1:0] == $past(d_i[HALF_W-1:0]) &&
       q_o[OUT_W-1:HALF_W] == $past(d_i[HALF_W-1:0]))); // R3

  AST_DUP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(dcs_i && csr_i) && cfg_split_i && cfg_alt_i) |=>
      (q_o == spread_pair($past(d_i[HALF_W-1:0])))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcs_i && csr_i) |=> ($stable(q_o) && $stable(qcs_o))); // R6

  AST_SELECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dcs_i && csr_i) |=> (qcs_o == $past(dcs_i))); // R7
endmodule

bind csab_reg_buffer csab_reg_buffer_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_chk (.*);

// File: tb/test_csab_reg_buffer.sv
`timescale 1ns/1ps
module test_csab_reg_buffer;
  localparam int DW = 25;
  localparam int HW = 14;
  localparam int OW = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_split_i = 1'b0;
  logic          cfg_alt_i = 1'b0;
  logic          dcs_i = 1'b0;
  logic          csr_i = 1'b0;
  logic [DW-1:0] d_i = '0;
  logic [OW-1:0] q_o;
  logic          qcs_o;

  int total = 0;
  int bad = 0;
  logic [OW-1:0] exp_q = '0;
  logic          exp_cs = 1'b0;
  logic [31:0]   seed = 32'h1bad_c0de;

  always #2 clk_i = ~clk_i;

  csab_reg_buffer i_csab_reg_buffer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_split_i(cfg_split_i), .cfg_alt_i(cfg_alt_i),
    .dcs_i(dcs_i), .csr_i(csr_i), .d_i(d_i), .q_o(q_o), .qcs_o(qcs_o)
  );

  function automatic logic [OW-1:0] model(input logic [DW-1:0] d, input logic sp, input logic al);
    logic [OW-1:0] r = '0;
    if (!sp) begin
      for (int j = 0; j < DW; j++) r[j] = d[j];
    end else if (!al) begin
      for (int k = 0; k < HW; k++) begin r[k] = d[k]; r[k+HW] = d[k]; end
    end else begin
      for (int k = 0; k < HW; k++) begin r[2*k] = d[k]; r[2*k+1] = d[k]; end
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] eq, input logic ecs);
    total++;
    if (q_o !== eq || qcs_o !== ecs) begin
      bad++;
      $display("FAIL %s: q=%h qcs=%b expected q=%h qcs=%b", req, q_o, qcs_o, eq, ecs);
    end
  endtask

  // drive after a falling edge, check at the next falling edge
  task automatic step(input logic [DW-1:0] d, input logic dcs, input logic csr,
                      input logic sp, input logic al, input string req);
    d_i = d; dcs_i = dcs; csr_i = csr; cfg_split_i = sp; cfg_alt_i = al;
    @(negedge clk_i);
    if (!(dcs && csr)) begin
      exp_q = model(d, sp, al);
      exp_cs = dcs;
    end
    check(req, exp_q, exp_cs);
  endtask

  function automatic string mode_req(input logic sp, input logic al);
    return !sp ? "R2" : (al ? "R4" : "R3");
  endfunction

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check("R1", '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q = '0; exp_cs = 1'b0;

    for (int m = 0; m < 3; m++) begin
      logic sp = (m != 0);
      logic al = (m == 2);
      for (int b = 0; b < DW; b++) step(DW'(1) << b, 1'b0, 1'b0, sp, al, mode_req(sp, al));
      for (int b = 0; b < DW; b++) step(~(DW'(1) << b), 1'b0, 1'b1, sp, al, mode_req(sp, al));
      for (int r = 0; r < 8; r++) begin
        seed = next_rand(seed);
        step(seed[DW-1:0], 1'b0, 1'b0, sp, al, mode_req(sp, al));
      end
      // R6/R7: every select combination
      for (int s = 0; s < 4; s++) begin
        seed = next_rand(seed);
        step(seed[DW-1:0], s[0], s[1], sp, al, (s == 3) ? "R6" : "R7");
        step(~seed[DW-1:0], 1'b1, 1'b1, sp, al, "R6");
      end
    end

    // R5: upper inputs ignored in 1:2 modes
    for (int a = 0; a < 2; a++) begin
      step(25'h0002a5c, 1'b0, 1'b0, 1'b1, a[0], "R5");
      step(25'h1ffc000 | 25'h0002a5c, 1'b0, 1'b0, 1'b1, a[0], "R5");
      check("R5", model(25'h0002a5c, 1'b1, a[0]), 1'b0);
    end

    // R9: config change between edges has no effect until the next edge
    step(25'h1234567, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    #0.5 cfg_split_i = 1'b1; cfg_alt_i = 1'b1;
    #1 check("R9", model(25'h1234567, 1'b0, 1'b0), 1'b0);
    @(negedge clk_i);
    exp_q = model(25'h1234567, 1'b1, 1'b1);
    check("R9", exp_q, 1'b0);

    // R1/R8: asynchronous reset mid-cycle while frozen
    step(25'h1555555, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    dcs_i = 1'b1; csr_i = 1'b1; d_i = '1;
    #1 rst_ni = 1'b0;
    #0.5 check("R1", '0, 1'b0);
    @(negedge clk_i);
    check("R8", '0, 1'b0);
    @(negedge clk_i);
    check("R8", '0, 1'b0);

    // R10: release with low data
    d_i = '0; dcs_i = 1'b0; csr_i = 1'b0;
    rst_ni = 1'b1;
    exp_q = '0; exp_cs = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      check("R10", '0, 1'b0);
    end
    step(25'h0f0f0f0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule